// File: doc/BRIEF.md
# Subcycle Recovery Counter

This block lives inside a memory peripheral that shares a bus with a processor. The processor splits each instruction cycle into eight subcycles and marks the cycle boundary with a sync marker. This block rebuilds the same eight one-hot subcycle strobes inside the peripheral. Bus and address logic in the peripheral can then act on exactly the same subcycle as the processor.

The block runs on the same fast clock as the processor's generator. It watches the same phase signal, which comes out of a register. When that phase signal becomes active, the block advances its one-hot ring. The register that detects the edge feeds the ring through logic only, so the ring moves on the same fast clock edge as the generator's ring.

When the sync marker is sampled at an advance, the ring is forced to subcycle 0. Until the first such marker arrives, every strobe stays inactive. A sticky locked flag is set by the first marker. A one-cycle error pulse flags a marker that arrives when the ring is not in its last subcycle.

Top module: `sc_recover`

## Requirements
- R1: While reset is asserted, and right after it is released, `sub_o` is all zero and `locked_o` and `resync_err_o` are 0.
- R2: Before the first sync marker has been taken, `sub_o` stays all zero whatever phase activity occurs, and `locked_o` stays 0.
- R3: An advance happens at the first rising fast clock edge that samples `clk1_i` high after a low sample. If `sync_i` is sampled high at that same edge, `sub_o` becomes 8'b0000_0001 (subcycle 0) right after that edge, whatever its previous state.
- R4: At an advance with `sync_i` low, the active bit moves from bit i to bit (i+1) mod 8. Bit i stands for subcycle i. The change is visible right after the advancing edge, with no extra cycle of delay.
- R5: `sub_o` never has more than one bit set.
- R6: `locked_o` rises at the advance that takes the first sync marker. It then stays 1 until reset.
- R7: A sync marker taken while locked, with bit 7 of `sub_o` clear, still realigns to subcycle 0. It also drives `resync_err_o` high for exactly one fast clock cycle, just after the advancing edge.
- R8: A sync marker taken while `sub_o` bit 7 is set produces no error pulse. The very first marker after reset also produces no error pulse.
- R9: Without an advance, `sub_o` holds its value. This includes the cycles while `clk1_i` stays high and any `sync_i` activity in those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | fast clock shared with the generator |
| rst_ni | input | 1 | asynchronous reset, active low |
| clk1_i | input | 1 | registered phase signal; its active edge advances the ring |
| sync_i | input | 1 | cycle boundary marker from the processor |
| sub_o | output | 8 | one-hot subcycle strobes, bit i = subcycle i |
| locked_o | output | 1 | set after the first sync realignment |
| resync_err_o | output | 1 | one-cycle pulse on a misplaced sync marker |

## Verification
The bench builds the block with its default parameters. That means eight subcycles and an advance on the rising edge of the phase signal, which matches the processor's ring. With eight subcycles, a full lap plus a sync back into subcycle 0 fits in a few dozen fast cycles. This covers the wrap from bit 7 to bit 0, a correctly placed marker and a misplaced one, all within one short run. Each advance is sampled both just before and just after the advancing edge, which makes any added cycle of skew visible.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic {
    ADV_RISE = 1'b0,
    ADV_FALL = 1'b1
  } adv_edge_e;

  localparam int unsigned SC_DEF_SUBS = 8;
endpackage

// File: rtl/sc_phase_edge.sv
module sc_phase_edge
  import sc_pkg::*;
#(
  parameter adv_edge_e EDGE = ADV_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_i,
  output logic adv_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= 1'b0;
    else         phase_q <= phase_i;
  end

  // combinational detect: ring moves on the same edge that first sees the phase
  generate
    if (EDGE == ADV_RISE) begin : g_rise
      assign adv_o = phase_i & ~phase_q;
    end else begin : g_fall
      assign adv_o = ~phase_i & phase_q;
    end
  endgenerate
endmodule

// File: rtl/sc_ring.sv
module sc_ring #(
  parameter int unsigned NUM_SUBS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adv_i,
  input  logic                load_i,
  output logic [NUM_SUBS-1:0] ring_o
);
  localparam logic [NUM_SUBS-1:0] FIRST = NUM_SUBS'(1);

  logic [NUM_SUBS-1:0] ring_q, ring_d;

  always_comb begin
    ring_d = ring_q;
    if (adv_i) begin
      if (load_i) ring_d = FIRST;
      else        ring_d = {ring_q[NUM_SUBS-2:0], ring_q[NUM_SUBS-1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ring_q <= '0;
    else         ring_q <= ring_d;
  end

  assign ring_o = ring_q;
endmodule

// File: rtl/sc_lock_mon.sv
module sc_lock_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic sync_i,
  input  logic last_i,
  output logic locked_o,
  output logic err_o
);
  logic locked_q, err_q, take;

  assign take = adv_i & sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      locked_q <= locked_q | take;
      err_q    <= take & locked_q & ~last_i;
    end
  end

  assign locked_o = locked_q;
  assign err_o    = err_q;
endmodule

// File: rtl/sc_recover.sv
module sc_recover
  import sc_pkg::*;
#(
  parameter int unsigned NUM_SUBS = SC_DEF_SUBS,
  parameter adv_edge_e   EDGE     = ADV_RISE
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clk1_i,
  input  logic                sync_i,
  output logic [NUM_SUBS-1:0] sub_o,
  output logic                locked_o,
  output logic                resync_err_o
);
  localparam int unsigned LAST = NUM_SUBS - 1;

  logic                adv;
  logic [NUM_SUBS-1:0] ring;

  sc_phase_edge #(.EDGE(EDGE)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_i(clk1_i),
    .adv_o  (adv)
  );

  sc_ring #(.NUM_SUBS(NUM_SUBS)) u_ring (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (adv),
    .load_i(sync_i),
    .ring_o(ring)
  );

  sc_lock_mon u_mon (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (adv),
    .sync_i  (sync_i),
    .last_i  (ring[LAST]),
    .locked_o(locked_o),
    .err_o   (resync_err_o)
  );

  assign sub_o = ring;
endmodule

// File: rtl/sc_recover_chk.sv
module sc_recover_chk #(
  parameter int unsigned NUM_SUBS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clk1_i,
  input logic                sync_i,
  input logic [NUM_SUBS-1:0] sub_o,
  input logic                locked_o,
  input logic                resync_err_o
);
  logic clk1_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk1_d <= 1'b0;
    else         clk1_d <= clk1_i;
  end

  logic step;
  assign step = clk1_i & ~clk1_d;

  p_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(sub_o));
  p_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni) !locked_o |-> sub_o == '0);
  p_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && sync_i) |=> sub_o == NUM_SUBS'(1));
  p_rot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !sync_i) |=> sub_o == {$past(sub_o[NUM_SUBS-2:0]), $past(sub_o[NUM_SUBS-1])});
  p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) locked_o |=> locked_o);
  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) resync_err_o |=> !resync_err_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni) !step |=> $stable(sub_o));
endmodule

bind sc_recover sc_recover_chk #(.NUM_SUBS(NUM_SUBS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clk1_i      (clk1_i),
  .sync_i      (sync_i),
  .sub_o       (sub_o),
  .locked_o    (locked_o),
  .resync_err_o(resync_err_o)
);

// File: tb/sc_recover_tb.sv
module sc_recover_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clk1_i = 1'b0;
  logic       sync_i = 1'b0;
  logic [7:0] sub_o;
  logic       locked_o, resync_err_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] sub_pre, sub_edge;
  logic       err_edge, err_after;

  always #2 clk = ~clk;

  sc_recover u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk1_i(clk1_i), .sync_i(sync_i),
    .sub_o(sub_o), .locked_o(locked_o), .resync_err_o(resync_err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one phase pulse; captures outputs before and right after the advancing edge
  task automatic adv(input logic s);
    @(negedge clk); sub_pre = sub_o; clk1_i = 1'b1; sync_i = s;
    @(negedge clk); sub_edge = sub_o; err_edge = resync_err_o;
    clk1_i = 1'b0; sync_i = 1'b0;
    @(negedge clk); err_after = resync_err_o;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; clk1_i = 1'b0; sync_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sub in reset", sub_o, 0);
    chk("R1 locked in reset", locked_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 sub after reset", sub_o, 0);
    chk("R1 err after reset", resync_err_o, 0);
  endtask

  task automatic t_unlocked();
    for (int i = 0; i < 3; i++) begin
      adv(1'b0);
      chk("R2 sub idle", sub_edge, 0);
    end
    chk("R2 not locked", locked_o, 0);
  endtask

  task automatic t_first_sync();
    adv(1'b1);
    chk("R3 pre-edge", sub_pre, 0);
    chk("R3 load sub0", sub_edge, 8'h01);
    chk("R6 locked", locked_o, 1);
    chk("R8 first sync no err", err_edge, 0);
  endtask

  task automatic t_rotate();
    for (int i = 1; i < 8; i++) begin
      adv(1'b0);
      chk("R4 before edge", sub_pre, 8'h01 << (i - 1));
      chk("R4 after edge", sub_edge, 8'h01 << i);
    end
  endtask

  task automatic t_good_sync();
    adv(1'b1);
    chk("R8 sync at last", sub_edge, 8'h01);
    chk("R8 no err", err_edge, 0);
  endtask

  task automatic t_bad_sync();
    adv(1'b0); adv(1'b0);
    chk("R4 at sub2", sub_edge, 8'h04);
    adv(1'b1);
    chk("R7 realign", sub_edge, 8'h01);
    chk("R7 err pulse", err_edge, 1);
    chk("R7 err one cycle", err_after, 0);
    chk("R6 stays locked", locked_o, 1);
  endtask

  task automatic t_ignore();
    logic [7:0] held;
    adv(1'b0);
    held = sub_o;
    @(negedge clk); clk1_i = 1'b1;
    @(negedge clk); held = sub_o;
    for (int i = 0; i < 4; i++) begin
      sync_i = i[0];
      @(negedge clk);
    end
    chk("R9 hold while high", sub_o, held);
    clk1_i = 1'b0; sync_i = 1'b1;
    repeat (3) @(negedge clk);
    sync_i = 1'b0;
    chk("R9 hold while low", sub_o, held);
    chk("R9 no err", resync_err_o, 0);
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk("R1 sub cleared", sub_o, 0);
    chk("R1 lock cleared", locked_o, 0);
    rst_ni = 1'b1;
    adv(1'b0);
    chk("R2 idle after reset", sub_edge, 0);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_unlocked();
    t_first_sync();
    t_rotate();
    t_good_sync();
    t_bad_sync();
    t_ignore();
    t_reset_again();
    finished = 1;
    summary();
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule